// File: doc/BRIEF.md
# Accumulator Bus Move Unit

This block sits between a 56-bit accumulator and a 24-bit data bus and carries out the moves between them. The accumulator is made of three fields: an 8-bit extension in bits 55..48, a 24-bit high word in bits 47..24 and a 24-bit low word in bits 23..0. A two-bit select picks one of four move targets: the whole accumulator, the high word, the low word or the extension. A strobe with a direction bit then requests a read or a write.

A read of the whole accumulator first passes the value through a scaling shifter. If the extension field of the shifted value holds significant bits, the bus word is clamped to the largest positive or largest negative 24-bit value. Each such clamp on a strobed read sets a sticky limit flag. Software can later test this flag to detect overflow in block-scaled arithmetic. Reads of the individual words are passed through unchanged.

A write of the whole accumulator sign-extends the bus word into the extension field and zeroes the low word. A write of a single field changes only that field. The extension field is narrow. It is sign-extended onto the bus on reads and takes only the low byte of the bus on writes.

Top module: `acc_bus_mover`

## Requirements
- R1: A synchronous active-high reset clears all 56 accumulator bits and the limit flag. The accumulator output is then 0 and a full read returns 0.
- R2: A write with select 00 (full) loads the bus word into bits 47..24. It copies bus bit 23 into bits 55..48 and clears bits 23..0.
- R3: A write with select 01 (high word) changes only bits 47..24. A write with select 10 (low word) changes only bits 23..0. All other bits keep their values.
- R4: A write with select 11 (extension) loads bus bits 7..0 into bits 55..48. Bus bits 23..8 are ignored and bits 47..0 are unchanged.
- R5: A read with select 11 drives the extension onto bus bits 7..0 and fills bus bits 23..8 with copies of extension bit 7.
- R6: Reads with select 01 or 10 return the raw high or low word. They apply no scaling and no clamping, and they never set the limit flag.
- R7: A full read scales by the 2-bit mode before extracting bits 47..24. Mode 00 applies no shift. Mode 01 applies an arithmetic right shift by one. Mode 10 applies a left shift by one. Mode 11 applies no shift.
- R8: When bits 55..47 of the shifted value are not all equal, the full read returns 0x7FFFFF if the unshifted accumulator bit 55 is 0, and 0x800000 if that bit is 1.
- R9: A strobed full read that clamps sets the limit flag at the next clock edge. The flag stays set until the clear input is sampled high. A clamp in the same cycle as a clear leaves the flag set.
- R10: Writes take effect at the rising clock edge. The bus output reflects the current select, mode and contents combinationally, whether or not a strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mv_sel | input | 2 | Target: 00 full, 01 high word, 10 low word, 11 extension |
| mv_req | input | 1 | Move strobe |
| mv_wr | input | 1 | Direction of a strobed move: 1 write, 0 read |
| bus_in | input | 24 | Bus word to be written |
| scale_mode | input | 2 | Scaling for full reads |
| lim_clr | input | 1 | Clears the limit flag |
| bus_out | output | 24 | Bus word read from the selected target |
| acc_out | output | 56 | Current accumulator contents |
| lim_flag | output | 1 | Sticky limit flag |

## Verification
Full reads are exercised with a small positive value under all four scaling modes. This shows that mode 11 behaves like mode 00 and that each shift direction is correct. The bench then uses values whose left shift, or whose preloaded extension, spills into bit 47 and above, with both signs. These cases separate correct clamping from plain truncation and show that the clamp polarity follows the true sign. The same oversized content is read through the high word, low word and extension selects. This proves the bypass and the byte sign-extension, and shows that the flag moves only on clamping full reads and that a clamp wins over a simultaneous clear. Field writes are interleaved with these reads, so any disturbance of neighbouring bits shows up on the accumulator output.

// File: rtl/acc_bus_pkg.sv
package acc_bus_pkg;

   typedef enum logic [1:0] {
      TGT_FULL = 2'b00,
      TGT_HIGH = 2'b01,
      TGT_LOW  = 2'b10,
      TGT_EXT  = 2'b11
   } acc_tgt_e;

   typedef enum logic [1:0] {
      SCL_NONE  = 2'b00,
      SCL_DOWN  = 2'b01,
      SCL_UP    = 2'b10,
      SCL_SPARE = 2'b11
   } acc_scale_e;

endpackage

// File: rtl/acc_bus_store.sv
module acc_bus_store
   import acc_bus_pkg::*;
#(
   parameter int EXT_W  = 8,
   parameter int WORD_W = 24,
   localparam int ACC_W = EXT_W + 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_go,
   input  acc_tgt_e          wr_tgt,
   input  logic [WORD_W-1:0] wr_data,
   output logic [ACC_W-1:0]  acc_q
);

   localparam int HI_LSB = WORD_W;
   localparam int EX_LSB = 2 * WORD_W;

   generate
      if (EXT_W < 2 || EXT_W > WORD_W) begin : g_bad_ext
         $error("acc_bus_store: EXT_W must lie in 2..WORD_W");
      end
      if (WORD_W < 4) begin : g_bad_word
         $error("acc_bus_store: WORD_W must be at least 4");
      end
   endgenerate

   logic [ACC_W-1:0] acc_d;

   always_comb begin
      acc_d = acc_q;
      if (wr_go) begin
         unique case (wr_tgt)
            TGT_FULL: acc_d = {{EXT_W{wr_data[WORD_W-1]}}, wr_data, {WORD_W{1'b0}}};
            TGT_HIGH: acc_d[EX_LSB-1:HI_LSB] = wr_data;
            TGT_LOW:  acc_d[HI_LSB-1:0]      = wr_data;
            TGT_EXT:  acc_d[ACC_W-1:EX_LSB]  = wr_data[EXT_W-1:0];
            default:  acc_d = acc_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_d;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (acc_q == '0)); // R1

   AST_FULL_WR_SEXT: assert property (@(posedge clk) disable iff (rst)
      (wr_go && wr_tgt == TGT_FULL) |=>
         (acc_q[HI_LSB-1:0] == '0) &&
         (acc_q[ACC_W-1:EX_LSB] == {EXT_W{acc_q[EX_LSB-1]}})); // R2

   AST_HIGH_WR_KEEP: assert property (@(posedge clk) disable iff (rst)
      (wr_go && wr_tgt == TGT_HIGH) |=>
         (acc_q[ACC_W-1:EX_LSB] == $past(acc_q[ACC_W-1:EX_LSB])) &&
         (acc_q[HI_LSB-1:0] == $past(acc_q[HI_LSB-1:0]))); // R3

   AST_EXT_WR_KEEP: assert property (@(posedge clk) disable iff (rst)
      (wr_go && wr_tgt == TGT_EXT) |=>
         (acc_q[EX_LSB-1:0] == $past(acc_q[EX_LSB-1:0]))); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_go |=> $stable(acc_q)); // R10

endmodule

// File: rtl/acc_bus_scaler.sv
module acc_bus_scaler
   import acc_bus_pkg::*;
#(
   parameter int ACC_W    = 56,
   parameter bit SCALE_EN = 1'b1
) (
   input  logic [ACC_W-1:0] acc_in,
   input  acc_scale_e       mode,
   output logic [ACC_W-1:0] acc_scaled
);

   generate
      if (ACC_W < 8) begin : g_bad_w
         $error("acc_bus_scaler: ACC_W too small");
      end
      if (SCALE_EN) begin : g_shift
         always_comb begin
            unique case (mode)
               SCL_DOWN: acc_scaled = {acc_in[ACC_W-1], acc_in[ACC_W-1:1]};
               SCL_UP:   acc_scaled = {acc_in[ACC_W-2:0], 1'b0};
               default:  acc_scaled = acc_in;
            endcase
         end
      end else begin : g_pass
         logic [1:0] mode_unused;
         assign mode_unused = mode;
         assign acc_scaled  = acc_in;
      end
   endgenerate

endmodule

// File: rtl/acc_bus_limiter.sv
module acc_bus_limiter #(
   parameter int EXT_W    = 8,
   parameter int WORD_W   = 24,
   parameter bit LIMIT_EN = 1'b1,
   localparam int ACC_W   = EXT_W + 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ACC_W-1:0]  scaled,
   input  logic              sign_in,
   input  logic              rd_full_go,
   input  logic              clr,
   output logic [WORD_W-1:0] word_out,
   output logic              clamped,
   output logic              flag_q
);

   localparam int GUARD_LSB = 2 * WORD_W - 1;
   localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] MAX_NEG = {1'b1, {(WORD_W-1){1'b0}}};

   logic [ACC_W-GUARD_LSB-1:0] guard;
   logic                       spill;

   assign guard = scaled[ACC_W-1:GUARD_LSB];

   generate
      if (LIMIT_EN) begin : g_lim
         assign spill = !((&guard) || !(|guard));
      end else begin : g_nolim
         logic [ACC_W-GUARD_LSB-1:0] guard_unused;
         assign guard_unused = guard;
         assign spill        = 1'b0;
      end
   endgenerate

   always_comb begin
      if (spill) word_out = sign_in ? MAX_NEG : MAX_POS;
      else       word_out = scaled[2*WORD_W-1:WORD_W];
   end
   assign clamped = spill;

   always_ff @(posedge clk) begin
      if (rst)                        flag_q <= 1'b0;
      else if (rd_full_go && clamped) flag_q <= 1'b1;
      else if (clr)                   flag_q <= 1'b0;
   end

   always_comb begin
      if (!rst && clamped)
         AST_CLAMP_VALUE: assert (word_out == MAX_POS || word_out == MAX_NEG); // R8
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag_q && !clr) |=> flag_q); // R9

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      (rd_full_go && clamped) |=> flag_q); // R9

   AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!flag_q && !(rd_full_go && clamped)) |=> !flag_q); // R6

endmodule

// File: rtl/acc_bus_mover.sv
module acc_bus_mover
   import acc_bus_pkg::*;
#(
   parameter int EXT_W    = 8,
   parameter int WORD_W   = 24,
   parameter bit SCALE_EN = 1'b1,
   parameter bit LIMIT_EN = 1'b1,
   localparam int ACC_W   = EXT_W + 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mv_sel,
   input  logic              mv_req,
   input  logic              mv_wr,
   input  logic [WORD_W-1:0] bus_in,
   input  logic [1:0]        scale_mode,
   input  logic              lim_clr,
   output logic [WORD_W-1:0] bus_out,
   output logic [ACC_W-1:0]  acc_out,
   output logic              lim_flag
);

   localparam int EX_LSB = 2 * WORD_W;

   acc_tgt_e          tgt;
   acc_scale_e        mode;
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_sh;
   logic [WORD_W-1:0] full_word;
   logic              clamped;
   logic              wr_go;
   logic              rd_full_go;

   assign tgt        = acc_tgt_e'(mv_sel);
   assign mode       = acc_scale_e'(scale_mode);
   assign wr_go      = mv_req && mv_wr;
   assign rd_full_go = mv_req && !mv_wr && (tgt == TGT_FULL);

   acc_bus_store #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_go   (wr_go),
      .wr_tgt  (tgt),
      .wr_data (bus_in),
      .acc_q   (acc_q)
   );

   acc_bus_scaler #(.ACC_W(ACC_W), .SCALE_EN(SCALE_EN)) u_scale (
      .acc_in     (acc_q),
      .mode       (mode),
      .acc_scaled (acc_sh)
   );

   acc_bus_limiter #(.EXT_W(EXT_W), .WORD_W(WORD_W), .LIMIT_EN(LIMIT_EN)) u_limit (
      .clk        (clk),
      .rst        (rst),
      .scaled     (acc_sh),
      .sign_in    (acc_q[ACC_W-1]),
      .rd_full_go (rd_full_go),
      .clr        (lim_clr),
      .word_out   (full_word),
      .clamped    (clamped),
      .flag_q     (lim_flag)
   );

   always_comb begin
      unique case (tgt)
         TGT_FULL: bus_out = full_word;
         TGT_HIGH: bus_out = acc_q[EX_LSB-1:WORD_W];
         TGT_LOW:  bus_out = acc_q[WORD_W-1:0];
         TGT_EXT:  bus_out = {{(WORD_W-EXT_W){acc_q[ACC_W-1]}}, acc_q[ACC_W-1:EX_LSB]};
         default:  bus_out = '0;
      endcase
   end

   assign acc_out = acc_q;

   always_comb begin
      if (!rst && tgt == TGT_EXT)
         AST_EXT_RD_SEXT: assert (bus_out[WORD_W-1:EXT_W] == {(WORD_W-EXT_W){bus_out[EXT_W-1]}}); // R5
      if (!rst && tgt == TGT_HIGH)
         AST_HIGH_RD_RAW: assert (bus_out == acc_out[EX_LSB-1:WORD_W]); // R6
   end

endmodule

// File: tb/acc_bus_mover_tb.sv
module acc_bus_mover_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  mv_sel = 2'b00;
   logic        mv_req = 1'b0;
   logic        mv_wr = 1'b0;
   logic [23:0] bus_in = '0;
   logic [1:0]  scale_mode = 2'b00;
   logic        lim_clr = 1'b0;
   logic [23:0] bus_out;
   logic [55:0] acc_out;
   logic        lim_flag;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   acc_bus_mover u_dut (
      .clk(clk), .rst(rst), .mv_sel(mv_sel), .mv_req(mv_req), .mv_wr(mv_wr),
      .bus_in(bus_in), .scale_mode(scale_mode), .lim_clr(lim_clr),
      .bus_out(bus_out), .acc_out(acc_out), .lim_flag(lim_flag)
   );

   task automatic check(input string tag, input logic [55:0] got, input logic [55:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [23:0] d);
      @(negedge clk);
      mv_sel = sel; bus_in = d; mv_req = 1'b1; mv_wr = 1'b1;
      @(negedge clk);
      mv_req = 1'b0; mv_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [1:0] mode,
                     input logic [23:0] exp, input string tag);
      @(negedge clk);
      mv_sel = sel; scale_mode = mode; mv_req = 1'b1; mv_wr = 1'b0;
      #1 check(tag, {32'h0, bus_out}, {32'h0, exp});
      @(negedge clk);
      mv_req = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk); lim_clr = 1'b1;
      @(negedge clk); lim_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 acc after reset", acc_out, 56'h0);
      check("R1 flag after reset", {55'h0, lim_flag}, 56'h0);
      rd(2'b00, 2'b00, 24'h000000, "R1 full read after reset");
   endtask

   task automatic t_full_write_modes();
      wr(2'b00, 24'h123456);
      check("R2 full write positive", acc_out, 56'h00_123456_000000);
      rd(2'b00, 2'b00, 24'h123456, "R7 mode 00");
      rd(2'b00, 2'b01, 24'h091A2B, "R7 mode 01 right shift");
      rd(2'b00, 2'b10, 24'h2468AC, "R7 mode 10 left shift");
      rd(2'b00, 2'b11, 24'h123456, "R7 mode 11 as no shift");
      check("R9 no clamp keeps flag low", {55'h0, lim_flag}, 56'h0);
   endtask

   task automatic t_pos_clamp();
      wr(2'b00, 24'h600000);
      rd(2'b00, 2'b10, 24'h7FFFFF, "R8 positive clamp after left shift");
      check("R9 flag set by clamp", {55'h0, lim_flag}, 56'h1);
      rd(2'b00, 2'b00, 24'h600000, "R9 unclamped read");
      check("R9 flag sticky", {55'h0, lim_flag}, 56'h1);
      clear_flag();
      check("R9 flag cleared", {55'h0, lim_flag}, 56'h0);
   endtask

   task automatic t_ext_and_bypass();
      wr(2'b11, 24'hABCD80);
      check("R4 ext write low byte only", acc_out, 56'h80_600000_000000);
      rd(2'b11, 2'b00, 24'hFFFF80, "R5 ext read negative");
      rd(2'b01, 2'b10, 24'h600000, "R6 high read raw");
      rd(2'b10, 2'b10, 24'h000000, "R6 low read raw");
      check("R6 sub reads leave flag", {55'h0, lim_flag}, 56'h0);
      rd(2'b00, 2'b00, 24'h800000, "R8 negative clamp from extension");
      check("R9 flag set by negative clamp", {55'h0, lim_flag}, 56'h1);
      clear_flag();
      wr(2'b11, 24'hFFFF7F);
      rd(2'b11, 2'b00, 24'h00007F, "R5 ext read positive");
   endtask

   task automatic t_field_writes();
      wr(2'b11, 24'h000080);
      wr(2'b01, 24'h0ABCDE);
      check("R3 high write keeps others", acc_out, 56'h80_0ABCDE_000000);
      wr(2'b10, 24'h112233);
      check("R3 low write keeps others", acc_out, 56'h80_0ABCDE_112233);
      @(negedge clk);
      mv_sel = 2'b10; bus_in = 24'h555555; mv_req = 1'b1; mv_wr = 1'b1;
      #1 check("R10 write not visible before edge", acc_out, 56'h80_0ABCDE_112233);
      @(negedge clk);
      mv_req = 1'b0; mv_wr = 1'b0;
      check("R10 write visible after edge", acc_out, 56'h80_0ABCDE_555555);
      @(negedge clk);
      mv_sel = 2'b01; #1
      check("R10 combinational read without strobe", {32'h0, bus_out}, 56'h0ABCDE);
   endtask

   task automatic t_negative_full();
      wr(2'b00, 24'h800000);
      check("R2 full write negative", acc_out, 56'hFF_800000_000000);
      rd(2'b00, 2'b01, 24'hC00000, "R7 mode 01 negative");
      clear_flag();
      @(negedge clk);
      mv_sel = 2'b00; scale_mode = 2'b10; mv_req = 1'b1; mv_wr = 1'b0; lim_clr = 1'b1;
      #1 check("R8 negative clamp after left shift", {32'h0, bus_out}, 56'h800000);
      @(negedge clk);
      mv_req = 1'b0; lim_clr = 1'b0;
      check("R9 clamp wins over clear", {55'h0, lim_flag}, 56'h1);
   endtask

   task automatic t_reset_again();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R1 reset clears acc", acc_out, 56'h0);
      check("R1 reset clears flag", {55'h0, lim_flag}, 56'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_full_write_modes();
      t_pos_clamp();
      t_ext_and_bypass();
      t_field_writes();
      t_negative_full();
      t_reset_again();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule